// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A watchdog that software programs and services over a small register bus. Once enabled it counts down a first stage on a prescaled tick. When that stage runs out it latches an interrupt status bit and hands over to a second countdown. When the second stage runs out it drives a reset request and records the event in a timeout flag. Only a power-on reset clears that flag, so software can tell after a restart that the watchdog caused it. Software keeps the system alive by reloading both stages before the first one expires.

The preload and reload registers are guarded. Each write to them must come straight after two unlock writes, 0x80 and then 0x86, to offset 0x0C. A lock bit freezes the enable so that it cannot be switched off again. A mode bit turns the block into a plain repeating timer that never requests a reset. The preloads are written as the timeout in seconds shifted left by 9. At the slow tick, which is about 1 kHz, the two stages together then take about 1024 ticks per second of timeout.

Top module: `twostage_wdt`

## Requirements
- R1: After reset, offsets 0x00, 0x04, 0x08, 0x0C and 0x14 read 0, offset 0x10 reads 0x03, and the interrupt output and reset output are both low.
- R2: A write to 0x00 (stage-1 preload), 0x04 (stage-2 preload) or 0x0C (reload) takes effect only if the two writes immediately before it were 0x80 and then 0x86 to 0x0C; otherwise it is ignored. Any write ends the unlock state. The preloads keep their low 20 bits.
- R3: The tick period T is 2^15 clocks when bit 2 of 0x10 is 0, and 2^5 clocks when it is 1. The prescaler restarts on every restart. Stage 1 expires, and bit 0 of 0x08 sets, exactly max(P1,1)*T clocks after the edge that restarts the block.
- R4: In watchdog mode, stage 2 expires exactly max(P2,1)*T clocks after stage 1. At that point bit 9 of 0x0C sets, and the reset output goes high when bit 5 of 0x10 is 0 and stays low when it is 1.
- R5: Writing 1 to bit 8 of the reload register through the unlock sequence reloads both counters and restarts stage 1, so the next stage-1 expiry falls max(P1,1)*T clocks after that write.
- R6: Bit 0 of 0x08 is sticky and is cleared by writing 1 to it, with no unlock needed. The interrupt output follows it when bits 1:0 of 0x10 are not 11, and is held low when they are 11.
- R7: Bit 9 of 0x0C is cleared by writing 1 to it through the unlock sequence. The system reset input does not clear it; only the power-on reset does. The reset output stays high until a reset.
- R8: In 0x14, bit 0 is the lock, bit 1 is the enable and bit 2 is the mode. Once the lock is set, writes cannot clear it, cannot clear the enable and cannot change the mode. Only a reset clears the lock.
- R9: With bit 2 of 0x14 set (timer mode), stage 1 expires again every max(P1,1)*T clocks. It never sets the timeout flag and never asserts the reset output.
- R10: While the enable is 0 nothing counts, even after a reload write. Setting the enable from 0 to 1 restarts stage 1 in the same way as a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstPorN | input | 1 | Power-on reset, active low, synchronous; clears everything |
| rstSysN | input | 1 | System reset, active low, synchronous; clears everything except the timeout flag |
| busWrEn | input | 1 | Write strobe for one cycle |
| busAddr | input | 5 | Byte offset for both writes and reads |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| irqOut | output | 1 | Stage-1 interrupt level |
| wdtRstOut | output | 1 | Reset request from stage-2 expiry |

## Verification
The assertions check on every cycle that protected strobes only follow the second unlock key and that the lock and the enable it freezes never fall. They also check that the reset output is sticky and only rises while reset generation is on, that the status bit and the timeout flag only fall on their clearing writes, and that timer mode never raises the timeout flag. The exact expiry cycles of both stages under each prescaler and preload cannot be seen from one cycle to the next. Neither can the restart of a keepalive, the rejection of broken unlock sequences, or the timeout flag surviving a system reset. The bench scenarios show those, including a sweep over small preload pairs.

// File: rtl/twostage_wdt_pkg.sv
package twostage_wdt_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_PRE1   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_PRE2   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CFG    = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_LOCK   = 5'h14;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h0000_0080;
  localparam logic [DATA_W-1:0] KEY_SECOND = 32'h0000_0086;

  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_OPEN} unlockSt_t;
  typedef enum logic [1:0] {ST_IDLE, ST_ONE, ST_TWO, ST_DONE} stage_t;

  // control -> datapath strobes
  typedef struct packed {
    logic ldPre1;
    logic ldPre2;
    logic restart;
    logic clrTimeout;
  } wdtStb_t;
endpackage

// File: rtl/twostage_wdt_ctrl.sv
module twostage_wdt_ctrl
  import twostage_wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              stage1Exp,
  output wdtStb_t           stb,
  output logic [1:0]        cfgIntType,
  output logic              cfgFast,
  output logic              cfgRstOff,
  output logic              lockQ,
  output logic              enQ,
  output logic              timerMode,
  output logic              intSt
);
  unlockSt_t ulSt, ulNext;
  logic keyHit1, keyHit2, openWr, wrCfg, wrLock, wrStat, wrReload;

  assign keyHit1  = (busAddr == OFS_RELOAD) && (busWrData == KEY_FIRST);
  assign keyHit2  = (busAddr == OFS_RELOAD) && (busWrData == KEY_SECOND);
  assign openWr   = busWrEn && (ulSt == UL_OPEN);
  assign wrCfg    = busWrEn && (busAddr == OFS_CFG);
  assign wrLock   = busWrEn && (busAddr == OFS_LOCK);
  assign wrStat   = busWrEn && (busAddr == OFS_STAT);
  assign wrReload = openWr && (busAddr == OFS_RELOAD);

  always_comb begin
    unique case (ulSt)
      UL_IDLE: ulNext = keyHit1 ? UL_HALF : UL_IDLE;
      UL_HALF: ulNext = keyHit2 ? UL_OPEN : UL_IDLE;
      default: ulNext = UL_IDLE;
    endcase
  end

  always_comb begin
    stb.ldPre1     = openWr && (busAddr == OFS_PRE1);
    stb.ldPre2     = openWr && (busAddr == OFS_PRE2);
    stb.clrTimeout = wrReload && busWrData[9];
    stb.restart    = (wrReload && busWrData[8]) ||
                     (wrLock && !enQ && busWrData[1]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ulSt       <= UL_IDLE;
      cfgIntType <= 2'b11;
      cfgFast    <= 1'b0;
      cfgRstOff  <= 1'b0;
      lockQ      <= 1'b0;
      enQ        <= 1'b0;
      timerMode  <= 1'b0;
      intSt      <= 1'b0;
    end else begin
      if (busWrEn) ulSt <= ulNext;
      if (wrCfg) begin
        cfgIntType <= busWrData[1:0];
        cfgFast    <= busWrData[2];
        cfgRstOff  <= busWrData[5];
      end
      if (wrLock) begin
        lockQ <= lockQ | busWrData[0];
        enQ   <= busWrData[1] | (lockQ & enQ);
        if (!lockQ) timerMode <= busWrData[2];
      end
      if (stage1Exp) intSt <= 1'b1;
      else if (wrStat && busWrData[0]) intSt <= 1'b0;
    end
  end
endmodule

// File: rtl/twostage_wdt_dp.sv
module twostage_wdt_dp
  import twostage_wdt_pkg::*;
#(
  parameter int CNT_W      = 20,
  parameter int SLOW_SHIFT = 15,
  parameter int FAST_SHIFT = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rstPorN,
  input  wdtStb_t          stb,
  input  logic [CNT_W-1:0] wrData,
  input  logic             enable,
  input  logic             fastTick,
  input  logic             timerMode,
  input  logic             rstOff,
  output logic [CNT_W-1:0] pre1Q,
  output logic [CNT_W-1:0] pre2Q,
  output logic             stage1Exp,
  output logic             timeoutFlag,
  output logic             wdtRstQ
);
  localparam logic [CNT_W-1:0]      CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [SLOW_SHIFT-1:0] PRE_ONE = {{(SLOW_SHIFT-1){1'b0}}, 1'b1};

  stage_t stage;
  logic [SLOW_SHIFT-1:0] preCnt;
  logic [CNT_W-1:0] cnt1, cnt2;
  logic running, tickNow, lastOne, lastTwo, stage2Exp;

  assign running   = enable && (stage == ST_ONE || stage == ST_TWO);
  assign tickNow   = running && (fastTick ? (&preCnt[FAST_SHIFT-1:0]) : (&preCnt));
  assign lastOne   = cnt1 <= CNT_ONE;
  assign lastTwo   = cnt2 <= CNT_ONE;
  assign stage1Exp = tickNow && (stage == ST_ONE) && lastOne;
  assign stage2Exp = tickNow && (stage == ST_TWO) && lastTwo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage   <= ST_IDLE;
      preCnt  <= '0;
      cnt1    <= '0;
      cnt2    <= '0;
      pre1Q   <= '0;
      pre2Q   <= '0;
      wdtRstQ <= 1'b0;
    end else begin
      if (stb.ldPre1) pre1Q <= wrData;
      if (stb.ldPre2) pre2Q <= wrData;
      if (stb.restart) begin
        preCnt <= '0;
        cnt1   <= pre1Q;
        cnt2   <= pre2Q;
        stage  <= ST_ONE;
      end else if (!enable) begin
        preCnt <= '0;
        stage  <= ST_IDLE;
      end else if (running) begin
        preCnt <= preCnt + PRE_ONE;
        if (tickNow) begin
          if (stage == ST_ONE) begin
            if (!lastOne) cnt1 <= cnt1 - CNT_ONE;
            else if (timerMode) cnt1 <= pre1Q;
            else begin
              cnt2  <= pre2Q;
              stage <= ST_TWO;
            end
          end else begin
            if (!lastTwo) cnt2 <= cnt2 - CNT_ONE;
            else begin
              stage <= ST_DONE;
              if (!rstOff) wdtRstQ <= 1'b1;
            end
          end
        end
      end
    end
  end

  // survives the system reset; only power-on clears it
  always_ff @(posedge clk) begin
    if (!rstPorN) timeoutFlag <= 1'b0;
    else if (stage2Exp) timeoutFlag <= 1'b1;
    else if (stb.clrTimeout) timeoutFlag <= 1'b0;
  end
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
  import twostage_wdt_pkg::*;
#(
  parameter int CNT_W      = 20,
  parameter int SLOW_SHIFT = 15,
  parameter int FAST_SHIFT = 5
) (
  input  logic              clk,
  input  logic              rstPorN,
  input  logic              rstSysN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut,
  output logic              wdtRstOut
);
  wdtStb_t stb;
  logic rstN, stage1Exp, cfgFast, cfgRstOff, lockQ, enQ, timerMode, intSt, timeoutFlag;
  logic [1:0] cfgIntType;
  logic [CNT_W-1:0] pre1Q, pre2Q;

  assign rstN = rstPorN & rstSysN;

  twostage_wdt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .stage1Exp(stage1Exp), .stb(stb),
    .cfgIntType(cfgIntType), .cfgFast(cfgFast), .cfgRstOff(cfgRstOff),
    .lockQ(lockQ), .enQ(enQ), .timerMode(timerMode), .intSt(intSt)
  );

  twostage_wdt_dp #(.CNT_W(CNT_W), .SLOW_SHIFT(SLOW_SHIFT), .FAST_SHIFT(FAST_SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .rstPorN(rstPorN), .stb(stb),
    .wrData(busWrData[CNT_W-1:0]), .enable(enQ), .fastTick(cfgFast),
    .timerMode(timerMode), .rstOff(cfgRstOff), .pre1Q(pre1Q), .pre2Q(pre2Q),
    .stage1Exp(stage1Exp), .timeoutFlag(timeoutFlag), .wdtRstQ(wdtRstOut)
  );

  assign irqOut = intSt && (cfgIntType != 2'b11);

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      OFS_PRE1:   busRdData = {{(DATA_W-CNT_W){1'b0}}, pre1Q};
      OFS_PRE2:   busRdData = {{(DATA_W-CNT_W){1'b0}}, pre2Q};
      OFS_STAT:   busRdData[0] = intSt;
      OFS_RELOAD: busRdData[9] = timeoutFlag;
      OFS_CFG:    busRdData[5:0] = {cfgRstOff, 2'b00, cfgFast, cfgIntType};
      OFS_LOCK:   busRdData[2:0] = {timerMode, enQ, lockQ};
      default:    busRdData = '0;
    endcase
  end
endmodule

// File: rtl/twostage_wdt_chk.sv
module twostage_wdt_chk
  import twostage_wdt_pkg::*;
(
  input logic              clk,
  input logic              rstPorN,
  input logic              rstSysN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic              wdtRstOut,
  input logic              lockQ,
  input logic              enQ,
  input logic              timerMode,
  input logic              cfgRstOff,
  input logic              intSt,
  input logic              timeoutFlag,
  input wdtStb_t           stb
);
  p_prot_pair_r2: assert property (@(posedge clk) disable iff (!rstPorN || !rstSysN)
    (stb.ldPre1 || stb.ldPre2 || stb.clrTimeout) |->
      $past(busWrEn && busAddr == OFS_RELOAD && busWrData == KEY_SECOND));

  p_rst_cfg_r4: assert property (@(posedge clk) disable iff (!rstPorN || !rstSysN)
    $rose(wdtRstOut) |-> $past(!cfgRstOff));

  p_irq_clear_r6: assert property (@(posedge clk) disable iff (!rstPorN || !rstSysN)
    $fell(intSt) |-> $past(busWrEn && busAddr == OFS_STAT && busWrData[0]));

  p_rst_sticky_r7: assert property (@(posedge clk) disable iff (!rstPorN || !rstSysN)
    wdtRstOut |=> wdtRstOut);

  p_tmo_clear_r7: assert property (@(posedge clk) disable iff (!rstPorN || !rstSysN)
    $fell(timeoutFlag) |-> $past(stb.clrTimeout));

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rstPorN || !rstSysN)
    lockQ |=> lockQ);

  p_lock_en_r8: assert property (@(posedge clk) disable iff (!rstPorN || !rstSysN)
    (lockQ && enQ) |=> enQ);

  p_timer_quiet_r9: assert property (@(posedge clk) disable iff (!rstPorN || !rstSysN)
    timerMode |-> !$rose(timeoutFlag));

  p_restart_src_r10: assert property (@(posedge clk) disable iff (!rstPorN || !rstSysN)
    stb.restart |-> busWrEn);
endmodule

bind twostage_wdt twostage_wdt_chk u_chk (
  .clk(clk), .rstPorN(rstPorN), .rstSysN(rstSysN), .busWrEn(busWrEn),
  .busAddr(busAddr), .busWrData(busWrData), .wdtRstOut(wdtRstOut),
  .lockQ(lockQ), .enQ(enQ), .timerMode(timerMode), .cfgRstOff(cfgRstOff),
  .intSt(intSt), .timeoutFlag(timeoutFlag), .stb(stb)
);

// File: tb/twostage_wdt_bench.sv
`timescale 1ns/1ps
module twostage_wdt_bench;
  logic clk = 1'b0;
  logic rstPorN = 1'b0, rstSysN = 1'b0, busWrEn = 1'b0;
  logic [4:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic irqOut, wdtRstOut;
  int checks = 0, fails = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  twostage_wdt u_twostage_wdt (
    .clk(clk), .rstPorN(rstPorN), .rstSysN(rstSysN), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irqOut(irqOut), .wdtRstOut(wdtRstOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic unlockWrite(input logic [4:0] a, input logic [31:0] d);
    busWrite(5'h0C, 32'h80);
    busWrite(5'h0C, 32'h86);
    busWrite(a, d);
  endtask

  task automatic readReg(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a;
    #1 v = busRdData;
  endtask

  task automatic doReset();
    busWrEn = 1'b0; rstPorN = 1'b0; rstSysN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstPorN = 1'b1; rstSysN = 1'b1;
  endtask

  task automatic sysReset();
    rstSysN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rstSysN = 1'b1;
  endtask

  // program, enable, and time both stages; enable write is the restart edge
  task automatic runStages(input int p1, input int p2, input bit fast, input bit rstOff);
    int t, e1, e2;
    doReset();
    busWrite(5'h10, {26'd0, rstOff, 2'b00, fast, 2'b00});
    unlockWrite(5'h00, p1);
    unlockWrite(5'h04, p2);
    t  = fast ? 32 : 32768;
    e1 = ((p1 == 0) ? 1 : p1) * t;
    e2 = ((p2 == 0) ? 1 : p2) * t;
    busWrite(5'h14, 32'h2);
    repeat (e1 - 1) @(posedge clk); #1;
    chk("R3 stage1 not yet", {31'd0, irqOut}, 0);
    @(posedge clk); #1;
    chk("R3 stage1 expiry", {31'd0, irqOut}, 1);
    repeat (e2 - 1) @(posedge clk); #1;
    chk("R4 stage2 not yet", {31'd0, wdtRstOut}, 0);
    @(posedge clk); #1;
    chk("R4 stage2 reset out", {31'd0, wdtRstOut}, rstOff ? 0 : 1);
    readReg(5'h0C, rv);
    chk("R4 timeout flag", rv, 32'h200);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual running expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    doReset();
    readReg(5'h00, rv); chk("R1 pre1", rv, 0);
    readReg(5'h04, rv); chk("R1 pre2", rv, 0);
    readReg(5'h08, rv); chk("R1 status", rv, 0);
    readReg(5'h0C, rv); chk("R1 reload", rv, 0);
    readReg(5'h10, rv); chk("R1 cfg", rv, 32'h3);
    readReg(5'h14, rv); chk("R1 lock", rv, 0);
    chk("R1 pins", {30'd0, irqOut, wdtRstOut}, 0);

    // R2 unlock sequence
    busWrite(5'h00, 32'h5);
    readReg(5'h00, rv); chk("R2 no unlock", rv, 0);
    busWrite(5'h0C, 32'h80); busWrite(5'h0C, 32'h86); busWrite(5'h10, 32'h3); busWrite(5'h00, 32'h6);
    readReg(5'h00, rv); chk("R2 interleaved write", rv, 0);
    busWrite(5'h0C, 32'h86); busWrite(5'h0C, 32'h80); busWrite(5'h00, 32'h7);
    readReg(5'h00, rv); chk("R2 wrong order", rv, 0);
    busWrite(5'h0C, 32'h80); busWrite(5'h08, 32'h0); busWrite(5'h0C, 32'h86); busWrite(5'h00, 32'h8);
    readReg(5'h00, rv); chk("R2 broken pair", rv, 0);
    unlockWrite(5'h00, 32'h9);
    readReg(5'h00, rv); chk("R2 accepted", rv, 32'h9);
    busWrite(5'h00, 32'hA);
    readReg(5'h00, rv); chk("R2 one write per unlock", rv, 32'h9);
    unlockWrite(5'h04, 32'hFFFF_FFFF);
    readReg(5'h04, rv); chk("R2 width", rv, 32'h000F_FFFF);

    // R3/R4 sweep of small preload pairs, fast tick
    for (int p1 = 0; p1 < 4; p1++)
      for (int p2 = 1; p2 < 4; p2++)
        runStages(p1, p2, 1'b1, 1'b0);
    // R3 slow tick
    runStages(1, 1, 1'b0, 1'b0);
    // R4 reset generation off
    runStages(2, 1, 1'b1, 1'b1);

    // R7 timeout flag and reset output persistence
    runStages(1, 1, 1'b1, 1'b0);
    busWrite(5'h0C, 32'h200);
    readReg(5'h0C, rv); chk("R7 unprotected clear ignored", rv, 32'h200);
    repeat (10) @(posedge clk); #1;
    chk("R7 reset out held", {31'd0, wdtRstOut}, 1);
    sysReset();
    #1 chk("R7 reset out cleared by reset", {31'd0, wdtRstOut}, 0);
    readReg(5'h0C, rv); chk("R7 flag survives sys reset", rv, 32'h200);
    unlockWrite(5'h0C, 32'h200);
    readReg(5'h0C, rv); chk("R7 protected clear", rv, 0);
    runStages(1, 1, 1'b1, 1'b0);
    doReset();
    readReg(5'h0C, rv); chk("R7 por clears flag", rv, 0);

    // R5 keepalive
    doReset();
    busWrite(5'h10, 32'h04);
    unlockWrite(5'h00, 32'd2);
    unlockWrite(5'h04, 32'd1);
    busWrite(5'h14, 32'h2);
    repeat (40) @(posedge clk);
    unlockWrite(5'h0C, 32'h100);
    repeat (63) @(posedge clk); #1;
    chk("R5 restarted, not yet", {31'd0, irqOut}, 0);
    @(posedge clk); #1;
    chk("R5 expiry after keepalive", {31'd0, irqOut}, 1);

    // R6 status and interrupt masking
    busWrite(5'h08, 32'h0);
    readReg(5'h08, rv); chk("R6 write 0 keeps status", rv, 1);
    busWrite(5'h10, 32'h07);
    chk("R6 type 11 masks irq", {31'd0, irqOut}, 0);
    readReg(5'h08, rv); chk("R6 status while masked", rv, 1);
    busWrite(5'h10, 32'h05);
    chk("R6 type 01 drives irq", {31'd0, irqOut}, 1);
    busWrite(5'h08, 32'h1);
    chk("R6 w1c irq", {31'd0, irqOut}, 0);
    readReg(5'h08, rv); chk("R6 w1c status", rv, 0);

    // R8 lock
    doReset();
    busWrite(5'h14, 32'h3);
    readReg(5'h14, rv); chk("R8 lock set", rv, 32'h3);
    busWrite(5'h14, 32'h0);
    readReg(5'h14, rv); chk("R8 enable stays", rv, 32'h3);
    busWrite(5'h14, 32'h4);
    readReg(5'h14, rv); chk("R8 mode frozen", rv, 32'h3);
    sysReset();
    readReg(5'h14, rv); chk("R8 reset clears lock", rv, 0);

    // R9 timer mode
    doReset();
    busWrite(5'h10, 32'h04);
    unlockWrite(5'h00, 32'd1);
    unlockWrite(5'h04, 32'd1);
    busWrite(5'h14, 32'h6);
    repeat (31) @(posedge clk); #1;
    chk("R9 first not yet", {31'd0, irqOut}, 0);
    @(posedge clk); #1;
    chk("R9 first expiry", {31'd0, irqOut}, 1);
    busWrite(5'h08, 32'h1);
    repeat (30) @(posedge clk); #1;
    chk("R9 second not yet", {31'd0, irqOut}, 0);
    @(posedge clk); #1;
    chk("R9 second expiry", {31'd0, irqOut}, 1);
    repeat (200) @(posedge clk); #1;
    chk("R9 no reset out", {31'd0, wdtRstOut}, 0);
    readReg(5'h0C, rv); chk("R9 no timeout flag", rv, 0);

    // R10 disabled block does not count
    doReset();
    busWrite(5'h10, 32'h04);
    unlockWrite(5'h00, 32'd1);
    repeat (200) @(posedge clk);
    readReg(5'h08, rv); chk("R10 disabled idle", rv, 0);
    unlockWrite(5'h0C, 32'h100);
    repeat (100) @(posedge clk); #1;
    chk("R10 reload while disabled", {31'd0, irqOut}, 0);
    readReg(5'h08, rv); chk("R10 status after reload disabled", rv, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule